// File: doc/BRIEF.md
# Serial Sampling Converter Front End with Power-Mode Control

This block is the digital front end on the device side of a three-wire serial sampling converter. It watches an active-low chip select and a serial clock. It counts the falling serial-clock edges of each conversion and shifts a 16-bit word out, most significant bit first, on a pin that can be tri-stated. The result comes in on a parallel port and is captured when a conversion starts.

When chip select rises, the number of falling edges counted so far selects the outcome. A rise after fewer than ten edges sends the block into shutdown. A rise after ten to fifteen edges aborts the word but keeps the block in normal mode. After sixteen edges the read is complete. A minimum quiet time, counted in system-clock cycles, must pass after a conversion ends before a new one may start.

Both pins are brought into the system-clock domain through two-flop synchronisers, and their edges are detected there. Status outputs show the power mode and give one-cycle pulses for completed conversions, aborted conversions and rejected starts.

Top module: `sadc_front`

## Requirements
- R1: Synchronous reset puts the block in shutdown (`pwr_normal`=0), disables the output driver (`sdo_oe`=0) and clears the edge count. The first accepted conversion after reset therefore starts at frame bit 15.
- R2: A falling edge of `cs_n` seen while the block is idle or in shutdown, with the quiet time expired, starts a conversion. It sets `pwr_normal`=1 and `sdo_oe`=1 and captures `sample`.
- R3: The frame is 16 bits, sent bit 15 first. Bits 15..12 are zero, the next RES_W bits carry `sample` MSB first, and the remaining low bits are zero. Bit 15 appears when the conversion starts, and frame bit 15-k is on `sdo_pad` after the k-th falling `sclk` edge.
- R4: On the 16th falling edge, `sdo_oe` drops to 0, `conv_done` pulses for one cycle and the block stays in normal mode.
- R5: A rise of `cs_n` after fewer than 10 falling edges of the conversion enters shutdown, pulses `conv_abort` and disables the driver.
- R6: A rise of `cs_n` after 10 to 15 falling edges keeps normal mode, pulses `conv_abort` and disables the driver, so the word is truncated.
- R7: In shutdown, `sclk` activity has no effect: `sdo_oe` and `pwr_normal` stay 0 until `cs_n` falls again.
- R8: If `cs_n` stays low after the 16th edge, further `sclk` edges neither drive `sdo_pad` nor produce another `conv_done`. A new conversion needs `cs_n` to go high and then low again.
- R9: Every completed or aborted conversion loads a quiet timer of QUIET_CYC system cycles. A `cs_n` fall that arrives while the timer runs is ignored: the mode is unchanged, `sdo_oe` stays 0 and `early_start` pulses. Once the timer expires, a start is accepted.
- R10: `conv_done` and `conv_abort` are one-cycle pulses and never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous active-low chip select |
| sclk | input | 1 | Asynchronous serial clock |
| sample | input | RES_W | Conversion result from the sample source |
| sdo_pad | output | 1 | Serial data, high impedance when not driven |
| sdo_oe | output | 1 | 1 while the serial data pin is driven |
| pwr_normal | output | 1 | 1 = normal mode, 0 = shutdown |
| conv_done | output | 1 | One-cycle pulse when a full word has been read |
| conv_abort | output | 1 | One-cycle pulse when chip select ends a word early |
| early_start | output | 1 | One-cycle pulse when a start is rejected during the quiet time |

## Verification
Some rules hold on every cycle, and the embedded assertions check those. The driver is never enabled in shutdown. The completion and abort pulses are exclusive and last one cycle. A rejected start never enables the driver. The edge count never passes sixteen. The block comes out of reset in shutdown.

The outcomes that depend on how many edges were counted when chip select rose can only be shown by the bench's scenarios. These are the split between shutdown, truncation and completion, and the bit-by-bit frame contents for different results. The same holds for ignoring edges while chip select is held low after a full word, and for the quiet-time rejection followed by an accepted start.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int FRAME_W    = 16;
    localparam int LEAD_ZEROS = 4;
    localparam int MAX_RES    = 12;
    localparam int SHUT_LIMIT = 10;
    localparam int CNT_W      = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_SHUT,
        ST_IDLE,
        ST_CONV,
        ST_HOLD
    } sadc_state_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sclk_fall;
    } pin_evt_t;

    function automatic logic [FRAME_W-1:0] make_frame(input logic [MAX_RES-1:0] res,
                                                      input int nbits);
        logic [FRAME_W-1:0] f;
        f = '0;
        for (int i = 0; i < MAX_RES; i++) begin
            if (i < nbits) begin
                f[FRAME_W-1-LEAD_ZEROS-i] = res[nbits-1-i];
            end
        end
        return f;
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync
    import sadc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n_async,
    input  logic     sclk_async,
    output pin_evt_t evt
);
    localparam int        NPIN    = 2;
    localparam logic [1:0] RST_VAL = 2'b10; // idx1 = chip select (idle high), idx0 = sclk

    logic [NPIN-1:0] raw, s1, s2, prev;

    assign raw = {cs_n_async, sclk_async};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[g]   <= RST_VAL[g];
                s2[g]   <= RST_VAL[g];
                prev[g] <= RST_VAL[g];
            end else begin
                s1[g]   <= raw[g];
                s2[g]   <= s1[g];
                prev[g] <= s2[g];
            end
        end
    end

    always_comb begin
        evt.cs_fall   = prev[1] & ~s2[1];
        evt.cs_rise   = ~prev[1] & s2[1];
        evt.sclk_fall = prev[0] & ~s2[0];
    end

endmodule

// File: rtl/sadc_quiet_timer.sv
module sadc_quiet_timer #(
    parameter int QUIET_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int QW = $clog2(QUIET_CYC + 1);

    logic [QW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= QW'(QUIET_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R9
    quiet_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= QW'(QUIET_CYC));

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
    import sadc_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] sample,
    output logic             bit_out,
    output logic [CNT_W-1:0] edge_cnt
);
    logic [FRAME_W-1:0] frame;
    logic [MAX_RES-1:0] ext;

    always_comb begin
        ext = '0;
        ext[RES_W-1:0] = sample;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame    <= '0;
            edge_cnt <= '0;
        end else if (load) begin
            frame    <= make_frame(ext, RES_W);
            edge_cnt <= '0;
        end else if (shift) begin
            frame    <= {frame[FRAME_W-2:0], 1'b0};
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign bit_out = frame[FRAME_W-1];

    // R3
    edge_cap_chk: assert property (@(posedge clk) disable iff (rst)
        edge_cnt <= CNT_W'(FRAME_W));

endmodule

// File: rtl/sadc_front.sv
module sadc_front
    import sadc_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int QUIET_CYC = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] sample,
    output logic             sdo_pad,
    output logic             sdo_oe,
    output logic             pwr_normal,
    output logic             conv_done,
    output logic             conv_abort,
    output logic             early_start
);
    pin_evt_t         evt;
    sadc_state_e      state;
    logic             quiet_busy;
    logic [CNT_W-1:0] edge_cnt;
    logic             bit_out;
    logic             start, reject, quit, finish, shift;

    sadc_sync i_sync (
        .clk        (clk),
        .rst        (rst),
        .cs_n_async (cs_n),
        .sclk_async (sclk),
        .evt        (evt)
    );

    always_comb begin
        start  = (state == ST_SHUT || state == ST_IDLE) && evt.cs_fall && !quiet_busy;
        reject = (state == ST_SHUT || state == ST_IDLE) && evt.cs_fall && quiet_busy;
        quit   = (state == ST_CONV) && evt.cs_rise;
        shift  = (state == ST_CONV) && evt.sclk_fall && !evt.cs_rise;
        finish = shift && (edge_cnt == CNT_W'(FRAME_W - 1));
    end

    sadc_quiet_timer #(.QUIET_CYC(QUIET_CYC)) i_quiet (
        .clk  (clk),
        .rst  (rst),
        .load (quit | finish),
        .busy (quiet_busy)
    );

    sadc_shifter #(.RES_W(RES_W)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .shift    (shift),
        .sample   (sample),
        .bit_out  (bit_out),
        .edge_cnt (edge_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_SHUT;
            conv_done   <= 1'b0;
            conv_abort  <= 1'b0;
            early_start <= 1'b0;
        end else begin
            conv_done   <= finish;
            conv_abort  <= quit;
            early_start <= reject;
            case (state)
                ST_SHUT, ST_IDLE: if (start) state <= ST_CONV;
                ST_CONV: begin
                    if (quit) begin
                        state <= (edge_cnt < CNT_W'(SHUT_LIMIT)) ? ST_SHUT : ST_IDLE;
                    end else if (finish) begin
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: if (evt.cs_rise) state <= ST_IDLE;
                default: state <= ST_SHUT;
            endcase
        end
    end

    assign sdo_oe     = (state == ST_CONV);
    assign pwr_normal = (state != ST_SHUT);
    assign sdo_pad    = sdo_oe ? bit_out : 1'bz;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwr_normal && !sdo_oe));

    // R7
    oe_off_shut_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_normal |-> !sdo_oe);

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(conv_done && conv_abort));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !conv_done);

    // R4
    done_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> (!sdo_oe && pwr_normal));

    // R9
    early_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        early_start |-> !sdo_oe);

endmodule

// File: tb/test_sadc_front.sv
module test_sadc_front;
    localparam int RES_W = 12;
    localparam int QUIET = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_n = 1'b1;
    logic             sclk = 1'b0;
    logic [RES_W-1:0] sample = '0;
    wire              sdo_pad;
    logic             sdo_oe, pwr_normal, conv_done, conv_abort, early_start;

    int tests = 0, fails = 0;
    int n_done = 0, n_abort = 0, n_early = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sadc_front #(.RES_W(RES_W), .QUIET_CYC(QUIET)) i_sadc_front (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sample      (sample),
        .sdo_pad     (sdo_pad),
        .sdo_oe      (sdo_oe),
        .pwr_normal  (pwr_normal),
        .conv_done   (conv_done),
        .conv_abort  (conv_abort),
        .early_start (early_start)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (conv_done)   n_done++;
            if (conv_abort)  n_abort++;
            if (early_start) n_early++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [RES_W-1:0] s, input int k);
        if (k < 4) return 1'b0;
        if (k < 4 + RES_W) return s[RES_W-1-(k-4)];
        return 1'b0;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_edge();
        sclk = 1'b1;
        wait_cyc(4);
        sclk = 1'b0;
        wait_cyc(5);
    endtask

    task automatic run_frame(input logic [RES_W-1:0] s, input int n, input bit keep_low);
        int d0, a0;
        d0 = n_done;
        a0 = n_abort;
        sample = s;
        cs_n = 1'b0;
        wait_cyc(6);
        chk(sdo_oe && pwr_normal, "R2 start", int'(sdo_oe), 1);
        chk(sdo_pad === exp_bit(s, 0), "R3 bit0", int'(sdo_pad), int'(exp_bit(s, 0)));
        for (int k = 1; k <= n; k++) begin
            fall_edge();
            if (k < 16) begin
                chk(sdo_oe == 1'b1, "R3 oe", int'(sdo_oe), 1);
                chk(sdo_pad === exp_bit(s, k), "R3 bit", int'(sdo_pad), int'(exp_bit(s, k)));
            end else begin
                chk(!sdo_oe && pwr_normal, "R4 end hiz", int'(sdo_oe), 0);
                chk(n_done == d0 + 1, "R4 done", n_done, d0 + 1);
            end
        end
        if (n == 16 && keep_low) begin
            fall_edge();
            fall_edge();
            chk(!sdo_oe, "R8 no drive", int'(sdo_oe), 0);
            chk(n_done == d0 + 1, "R8 no redo", n_done, d0 + 1);
        end
        cs_n = 1'b1;
        wait_cyc(6);
        if (n < 10) begin
            chk(!pwr_normal, "R5 shutdown", int'(pwr_normal), 0);
            chk(n_abort == a0 + 1, "R5 abort", n_abort, a0 + 1);
        end else if (n < 16) begin
            chk(pwr_normal, "R6 stays normal", int'(pwr_normal), 1);
            chk(n_abort == a0 + 1, "R6 abort", n_abort, a0 + 1);
        end else begin
            chk(pwr_normal, "R4 normal", int'(pwr_normal), 1);
            chk(n_abort == a0, "R10 no abort", n_abort, a0);
        end
        chk(!sdo_oe, "R5 R6 hiz", int'(sdo_oe), 0);
        wait_cyc(QUIET + 10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int e0, d0, seed;
        seed = int'($urandom(32'd12345));
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        // R1 reset state
        chk(!pwr_normal, "R1 shutdown", int'(pwr_normal), 0);
        chk(!sdo_oe, "R1 hiz", int'(sdo_oe), 0);
        // R7 clocks in shutdown are ignored
        fall_edge();
        fall_edge();
        chk(!sdo_oe && !pwr_normal, "R7 ignore sclk", int'(sdo_oe), 0);

        run_frame(12'hABC, 16, 1'b1);
        run_frame(12'hFFF, 16, 1'b0);
        run_frame(12'h5A3, 9, 1'b0);
        run_frame(12'h123, 10, 1'b0);
        run_frame(12'h800, 0, 1'b0);
        run_frame(12'h001, 15, 1'b0);

        // R9 early start after completion is rejected
        e0 = n_early;
        sample = 12'h321;
        cs_n = 1'b0;
        wait_cyc(6);
        for (int k = 1; k <= 16; k++) fall_edge();
        cs_n = 1'b1;
        wait_cyc(3);
        cs_n = 1'b0;
        wait_cyc(6);
        chk(!sdo_oe && pwr_normal, "R9 ignored start", int'(sdo_oe), 0);
        chk(n_early == e0 + 1, "R9 early flag", n_early, e0 + 1);
        cs_n = 1'b1;
        wait_cyc(QUIET + 10);

        // R9 early start in shutdown is rejected, mode stays shutdown
        e0 = n_early;
        cs_n = 1'b0;
        wait_cyc(6);
        fall_edge();
        cs_n = 1'b1;
        wait_cyc(3);
        cs_n = 1'b0;
        wait_cyc(6);
        chk(!pwr_normal && !sdo_oe, "R9 shut kept", int'(pwr_normal), 0);
        chk(n_early == e0 + 1, "R9 early in shut", n_early, e0 + 1);
        cs_n = 1'b1;
        wait_cyc(QUIET + 10);
        // R9 accepted once quiet time expired
        run_frame(12'h7E1, 16, 1'b0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [RES_W-1:0] s;
            int n;
            bit kl;
            s  = RES_W'($urandom);
            n  = int'($urandom_range(16, 0));
            kl = 1'($urandom_range(1, 0));
            run_frame(s, n, kl);
        end

        d0 = n_done;
        wait_cyc(10);
        chk(n_done == d0, "R10 no stray done", n_done, d0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule